// File: doc/BRIEF.md
# Half-Bridge Gate Enable and Status Composer

This block sits between a committed serial control frame and the power stage of a six-leg half-bridge driver. It latches a control word when the frame is committed and derives from it twelve registered gate enables, one per high-side and low-side switch. It gates those enables with the run conditions, the fault masks and the global disables that a supervisor provides. It also drives the open-load test current enables and composes the sixteen-bit status word that is shifted back to the host.

Each leg is managed by a small state machine with four states. LEG_IDLE has both switches off. LEG_LOW has only the low side on. LEG_HIGH has only the high side on. LEG_DEAD has both switches off while a dead-time counter runs down. The transitions are as follows. IDLE goes to LOW or HIGH as soon as that side is wanted. LOW or HIGH goes to DEAD when its side stops being wanted. DEAD reloads nothing while it counts. When the count reaches zero, DEAD goes to LOW, HIGH or IDLE, depending on what is wanted at that moment. A side is wanted when its control bit is set, the block is in run mode, no supply or thermal disable is active, its own fault mask is clear, and the opposite side of the same leg is not also commanded.

Control and status share one bit layout. Bit 0 is a flag bit. For leg k (0 to 5), bit 2k+1 is the low side and bit 2k+2 is the high side. Bits 13, 14 and 15 carry the mode and run information.

Top module: `hb_gate_status`

## Requirements
- R1: After reset the latched control word is 0xE000: bit 15 (run) is 1, bit 14 is 1, bit 13 (open-load test, active low) is 1, and all other bits are 0. All gate enables and all open-load test enables are 0. With the inhibit pin high and all flags low, the status word reads 0x0000.
- R2: `ctrl_word` is captured only on a clock edge where `commit` is 1. The gate enables reflect a committed word after the second rising edge, counting from the edge that samples `commit`, and all legs update in the same cycle. A change on `ctrl_word` without `commit` has no effect.
- R3: Switches may conduct only when control bit 15 is 1 and `inh_pin` is 1. If either is 0, every gate enable is 0 after the next rising edge.
- R4: Status bit 14 is 1 whenever control bit 15 or `inh_pin` is 0, and 0 otherwise.
- R5: If both the low-side bit and the high-side bit of one leg are set in the control word, both switches of that leg stay off. The other legs are not affected.
- R6: When a leg moves from one side to the other, both of its gate enables are 0 for exactly DEAD_CYC cycles (default 4) before the new side turns on.
- R7: `fault_mask[i]` = 1 holds switch i off. `sup_disable` = 1 holds all switches off. Gate index 2k is the low side of leg k and index 2k+1 is the high side.
- R8: With control bit 13 at 0, `ol_test_en[i]` is 1 for every switch i whose gate enable is 0, and 0 for every switch whose gate enable is 1. With bit 13 at 1, all test enables are 0.
- R9: Status bit i+1 shows `gate_en[i]` when control bit 13 is 1. When bit 13 is 0, it shows 1 for a switch that is on and `olc_hit[i]` for a switch that is off.
- R10: Status bit 0 follows `prewarn` directly, without latching. Bit 13 follows `scd_flag` and bit 15 follows `psf_flag`.
- R11: While `tshut` is 1, the status word reads 0xFFFF and every gate enable is 0 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit | input | 1 | One-cycle strobe that latches `ctrl_word` |
| ctrl_word | input | 16 | Control frame to be committed |
| inh_pin | input | 1 | Hardware run enable, low means standby |
| sup_disable | input | 1 | Global switch-off from the supply supervisor |
| fault_mask | input | 12 | Per-switch off request from short-circuit protection |
| olc_hit | input | 12 | Per-switch open-load comparator result |
| prewarn | input | 1 | Temperature prewarning flag |
| tshut | input | 1 | Thermal shutdown flag |
| scd_flag | input | 1 | Latched short-circuit flag |
| psf_flag | input | 1 | Latched supply-fail flag |
| gate_en | output | 12 | Registered gate enables, 2k = low side, 2k+1 = high side of leg k |
| ol_test_en | output | 12 | Open-load test current enables |
| status_word | output | 16 | Composed status word |

## Verification
The bench first drives frames that turn on one side of different legs, and checks that every commit changes all legs in the same cycle. It then swaps one leg from its low side to its high side, which exposes the dead interval and its exact length. A frame that sets both sides of one leg shows that the conflict is resolved per leg and does not spread to the other legs. The inhibit pin, the run bit, a single fault mask and the global disable are each dropped in turn; this separates standby, which also sets the status flag, from the fault paths, which leave that flag clear. The open-load comparator is driven with all ones and then with an alternating pattern, in test mode and in normal mode, so the bench can tell on-switches, off-switches with a hit, and an ignored comparator apart. The thermal shutdown override is applied last, on top of the other flags.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        LEG_IDLE = 2'd0,
        LEG_LOW  = 2'd1,
        LEG_HIGH = 2'd2,
        LEG_DEAD = 2'd3
    } leg_state_t;

endpackage

// File: rtl/hbg_ctrl_reg.sv
module hbg_ctrl_reg #(
    parameter int          WORD_W  = 16,
    parameter logic [WORD_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= RST_VAL;
        else if (commit)
            word_q <= word_in;
    end

    // R2
    commit_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (word_q == $past(word_in)));

    // R2
    hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(word_q));

endmodule

// File: rtl/hbg_leg_fsm.sv
module hbg_leg_fsm
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_lo,
    input  logic want_hi,
    output logic lo_en,
    output logic hi_en
);

    localparam int CNT_W = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] DEAD_LD  = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0] DEAD_MAX = CNT_W'(DEAD_CYC);

    leg_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LEG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LEG_IDLE: begin
                if (want_lo)      state_d = LEG_LOW;
                else if (want_hi) state_d = LEG_HIGH;
            end
            LEG_LOW: begin
                if (!want_lo) begin
                    state_d = LEG_DEAD;
                    cnt_d   = DEAD_LD;
                end
            end
            LEG_HIGH: begin
                if (!want_hi) begin
                    state_d = LEG_DEAD;
                    cnt_d   = DEAD_LD;
                end
            end
            LEG_DEAD: begin
                if (cnt_q == '0) begin
                    if (want_lo)      state_d = LEG_LOW;
                    else if (want_hi) state_d = LEG_HIGH;
                    else              state_d = LEG_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        lo_en = 1'b0;
        hi_en = 1'b0;
        unique case (state_q)
            LEG_LOW:  lo_en = 1'b1;
            LEG_HIGH: hi_en = 1'b1;
            default: ;
        endcase
    end

    // gap tracking for the dead-time checks
    logic [CNT_W-1:0] gap_q;
    logic             last_lo_q, last_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= DEAD_MAX;
            last_lo_q <= 1'b0;
            last_hi_q <= 1'b0;
        end else begin
            if (lo_en || hi_en)       gap_q <= '0;
            else if (gap_q != DEAD_MAX) gap_q <= gap_q + 1'b1;
            if (lo_en) begin
                last_lo_q <= 1'b1;
                last_hi_q <= 1'b0;
            end else if (hi_en) begin
                last_lo_q <= 1'b0;
                last_hi_q <= 1'b1;
            end
        end
    end

    // R6
    dead_gap_to_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_en) && last_lo_q) |-> (gap_q >= DEAD_MAX));

    // R6
    dead_gap_to_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lo_en) && last_hi_q) |-> (gap_q >= DEAD_MAX));

    // R5
    low_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_en |-> $past(want_lo));

    // R5
    high_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_en |-> $past(want_hi));

endmodule

// File: rtl/hbg_status.sv
module hbg_status #(
    parameter int N_SW = 12
) (
    input  logic              test_mode,
    input  logic              standby,
    input  logic              prewarn,
    input  logic              tshut,
    input  logic              scd_flag,
    input  logic              psf_flag,
    input  logic [N_SW-1:0]   gate_en,
    input  logic [N_SW-1:0]   olc_hit,
    output logic [N_SW-1:0]   ol_test_en,
    output logic [N_SW+3:0]   status_word
);

    localparam int WORD_W   = N_SW + 4;
    localparam int SCD_BIT  = N_SW + 1;
    localparam int STBY_BIT = N_SW + 2;
    localparam int PSF_BIT  = N_SW + 3;

    assign ol_test_en = {N_SW{test_mode}} & ~gate_en;

    always_comb begin
        status_word = '0;
        status_word[0] = prewarn;
        for (int i = 0; i < N_SW; i++) begin
            status_word[i + 1] = gate_en[i] | (test_mode & olc_hit[i]);
        end
        status_word[SCD_BIT]  = scd_flag;
        status_word[STBY_BIT] = standby;
        status_word[PSF_BIT]  = psf_flag;
        if (tshut)
            status_word = {WORD_W{1'b1}};
    end

endmodule

// File: rtl/hb_gate_status.sv
module hb_gate_status #(
    parameter int N_BRIDGE = 6,
    parameter int DEAD_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [2*N_BRIDGE+3:0]   ctrl_word,
    input  logic                    inh_pin,
    input  logic                    sup_disable,
    input  logic [2*N_BRIDGE-1:0]   fault_mask,
    input  logic [2*N_BRIDGE-1:0]   olc_hit,
    input  logic                    prewarn,
    input  logic                    tshut,
    input  logic                    scd_flag,
    input  logic                    psf_flag,
    output logic [2*N_BRIDGE-1:0]   gate_en,
    output logic [2*N_BRIDGE-1:0]   ol_test_en,
    output logic [2*N_BRIDGE+3:0]   status_word
);

    localparam int N_SW     = 2 * N_BRIDGE;
    localparam int WORD_W   = N_SW + 4;
    localparam int TEST_BIT = N_SW + 1;
    localparam int AUX_BIT  = N_SW + 2;
    localparam int RUN_BIT  = N_SW + 3;
    localparam logic [WORD_W-1:0] CTRL_RST = {3'b111, {(N_SW + 1){1'b0}}};

    logic [WORD_W-1:0] ctrl_q;
    logic              run_ok;
    logic              allow;
    logic              test_mode;
    logic              unused_bits;

    hbg_ctrl_reg #(
        .WORD_W  (WORD_W),
        .RST_VAL (CTRL_RST)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .word_in (ctrl_word),
        .word_q  (ctrl_q)
    );

    assign run_ok      = ctrl_q[RUN_BIT] & inh_pin;
    assign allow       = run_ok & ~sup_disable & ~tshut;
    assign test_mode   = ~ctrl_q[TEST_BIT];
    assign unused_bits = ctrl_q[0] ^ ctrl_q[AUX_BIT];

    for (genvar k = 0; k < N_BRIDGE; k++) begin : g_leg
        logic cmd_lo, cmd_hi, clash, want_lo, want_hi;
        assign cmd_lo  = ctrl_q[2*k + 1];
        assign cmd_hi  = ctrl_q[2*k + 2];
        assign clash   = cmd_lo & cmd_hi;
        assign want_lo = cmd_lo & ~clash & allow & ~fault_mask[2*k];
        assign want_hi = cmd_hi & ~clash & allow & ~fault_mask[2*k + 1];

        hbg_leg_fsm #(
            .DEAD_CYC (DEAD_CYC)
        ) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .want_lo (want_lo),
            .want_hi (want_hi),
            .lo_en   (gate_en[2*k]),
            .hi_en   (gate_en[2*k + 1])
        );
    end

    hbg_status #(
        .N_SW (N_SW)
    ) u_status (
        .test_mode   (test_mode),
        .standby     (~run_ok),
        .prewarn     (prewarn),
        .tshut       (tshut),
        .scd_flag    (scd_flag),
        .psf_flag    (psf_flag),
        .gate_en     (gate_en),
        .olc_hit     (olc_hit),
        .ol_test_en  (ol_test_en),
        .status_word (status_word)
    );

    // R3
    standby_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inh_pin |=> (gate_en == '0));

    // R11
    tshut_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tshut |=> (gate_en == '0));

    // R7
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sup_disable |=> (gate_en == '0));

    // R7
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((gate_en & $past(fault_mask)) == '0));

endmodule

// File: tb/hb_gate_status_test.sv
module hb_gate_status_test;

    localparam int NB   = 6;
    localparam int NS   = 2 * NB;
    localparam int DEAD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          commit = 1'b0;
    logic [15:0]   ctrl_word = 16'h0000;
    logic          inh_pin = 1'b1;
    logic          sup_disable = 1'b0;
    logic [NS-1:0] fault_mask = '0;
    logic [NS-1:0] olc_hit = '0;
    logic          prewarn = 1'b0;
    logic          tshut = 1'b0;
    logic          scd_flag = 1'b0;
    logic          psf_flag = 1'b0;
    logic [NS-1:0] gate_en;
    logic [NS-1:0] ol_test_en;
    logic [15:0]   status_word;

    always #10 clk = ~clk;

    hb_gate_status #(.N_BRIDGE(NB), .DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .commit(commit), .ctrl_word(ctrl_word),
        .inh_pin(inh_pin), .sup_disable(sup_disable), .fault_mask(fault_mask),
        .olc_hit(olc_hit), .prewarn(prewarn), .tshut(tshut),
        .scd_flag(scd_flag), .psf_flag(psf_flag), .gate_en(gate_en),
        .ol_test_en(ol_test_en), .status_word(status_word)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_ctrl = 16'hE000;
    int          m_side[NB];
    int          m_wait[NB];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [NS-1:0] m_gates();
        logic [NS-1:0] g = '0;
        for (int k = 0; k < NB; k++) begin
            if (m_side[k] == 1) g[2*k]     = 1'b1;
            if (m_side[k] == 2) g[2*k + 1] = 1'b1;
        end
        return g;
    endfunction

    task automatic model_edge();
        logic allow;
        if (!rst_n) begin
            m_ctrl = 16'hE000;
            for (int k = 0; k < NB; k++) begin
                m_side[k] = 0;
                m_wait[k] = 0;
            end
            return;
        end
        allow = m_ctrl[15] && inh_pin && !sup_disable && !tshut;
        for (int k = 0; k < NB; k++) begin
            bit wl, wh;
            int want;
            wl = m_ctrl[2*k+1] && allow && !fault_mask[2*k];
            wh = m_ctrl[2*k+2] && allow && !fault_mask[2*k+1];
            if (m_ctrl[2*k+1] && m_ctrl[2*k+2]) begin
                wl = 0;
                wh = 0;
            end
            want = wl ? 1 : (wh ? 2 : 0);
            if (m_side[k] != 0) begin
                if (m_side[k] != want) begin
                    m_side[k] = 0;
                    m_wait[k] = DEAD;
                end
            end else begin
                if (m_wait[k] > 0) m_wait[k]--;
                if (m_wait[k] == 0) m_side[k] = want;
            end
        end
        if (commit) m_ctrl = ctrl_word;
    endtask

    task automatic compare(string tag);
        logic [NS-1:0] g;
        logic [NS-1:0] ol;
        logic [15:0]   st;
        logic          tm;
        g  = m_gates();
        tm = !m_ctrl[13];
        ol = tm ? ~g : '0;
        st = '0;
        st[0] = prewarn;
        for (int i = 0; i < NS; i++) st[i+1] = g[i] | (tm & olc_hit[i]);
        st[13] = scd_flag;
        st[14] = !(m_ctrl[15] && inh_pin);
        st[15] = psf_flag;
        if (tshut) st = 16'hFFFF;
        chk({tag, " gate_en"}, 32'(gate_en), 32'(g));
        chk({tag, " ol_test_en"}, 32'(ol_test_en), 32'(ol));
        chk({tag, " status"}, 32'(status_word), 32'(st));
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        #1;
        compare(tag);
    endtask

    task automatic steps(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic send(logic [15:0] w, string tag);
        ctrl_word = w;
        commit = 1'b1;
        step(tag);
        commit = 1'b0;
        step(tag);
    endtask

    initial begin
        for (int k = 0; k < NB; k++) begin
            m_side[k] = 0;
            m_wait[k] = 0;
        end
        steps(3, "R1");
        rst_n = 1'b1;
        step("R1");
        // R1 reset state
        chk("R1 reset gates", 32'(gate_en), 32'h0);
        chk("R1 reset status", 32'(status_word), 32'h0);
        chk("R1 reset ol test", 32'(ol_test_en), 32'h0);

        // R2 leg0 low + leg1 high, run, test off
        send(16'hA012, "R2");
        chk("R2 commit gates", 32'(gate_en), 32'h009);
        chk("R2 commit status", 32'(status_word), 32'h0012);
        ctrl_word = 16'hFFFF;
        steps(3, "R2");
        chk("R2 no commit ignored", 32'(gate_en), 32'h009);

        // R6 leg0 swaps low -> high
        begin
            int gap = 0;
            ctrl_word = 16'hA014;
            commit = 1'b1;
            step("R6");
            commit = 1'b0;
            for (int i = 0; i < 10; i++) begin
                step("R6");
                if (gate_en[1:0] == 2'b00) gap++;
            end
            chk("R6 dead cycles", 32'(gap), 32'(DEAD));
            chk("R6 after swap", 32'(gate_en), 32'h00A);
        end

        // R5 leg2 both sides commanded
        send(16'hA074, "R5");
        steps(4, "R5");
        chk("R5 clash off", 32'(gate_en), 32'h00A);
        send(16'hA014, "R5");
        steps(6, "R5");

        // R3 / R4 hardware inhibit
        inh_pin = 1'b0;
        step("R3");
        chk("R3 pin standby gates", 32'(gate_en), 32'h0);
        chk("R4 pin standby status", 32'(status_word), 32'h4000);
        inh_pin = 1'b1;
        steps(8, "R3");
        chk("R3 pin run again", 32'(gate_en), 32'h00A);
        // software run bit low
        send(16'h2014, "R4");
        chk("R3 soft standby gates", 32'(gate_en), 32'h0);
        chk("R4 soft standby status", 32'(status_word), 32'h4000);
        send(16'hA014, "R3");
        steps(6, "R3");

        // R7 per-switch mask and global disable
        fault_mask = 12'h008;
        steps(6, "R7");
        chk("R7 mask one switch", 32'(gate_en), 32'h002);
        fault_mask = '0;
        steps(6, "R7");
        sup_disable = 1'b1;
        step("R7");
        chk("R7 global disable", 32'(gate_en), 32'h0);
        sup_disable = 1'b0;
        steps(6, "R7");

        // R8 / R9 open-load test mode
        send(16'h8014, "R8");
        olc_hit = 12'hFFF;
        step("R9");
        chk("R8 test enables", 32'(ol_test_en), 32'hFF5);
        chk("R9 status all hits", 32'(status_word), 32'h1FFE);
        olc_hit = 12'h555;
        step("R9");
        chk("R9 status alternate hits", 32'(status_word), 32'h0ABE);
        send(16'hA014, "R9");
        chk("R9 hits ignored normal", 32'(status_word), 32'h0014);
        chk("R8 test enables off", 32'(ol_test_en), 32'h0);

        // R10 flag passthrough
        prewarn = 1'b1; scd_flag = 1'b1; psf_flag = 1'b1;
        step("R10");
        chk("R10 flags", 32'(status_word), 32'hA015);
        prewarn = 1'b0;
        step("R10");
        chk("R10 prewarn clears", 32'(status_word), 32'hA014);

        // R11 thermal shutdown
        tshut = 1'b1;
        step("R11");
        chk("R11 status all ones", 32'(status_word), 32'hFFFF);
        chk("R11 gates off", 32'(gate_en), 32'h0);
        steps(3, "R11");
        tshut = 1'b0;
        steps(8, "R11");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule